// File: doc/BRIEF.md
# Operand-Gated Split Adder

This block is a two's-complement adder for narrow image-processing datapaths, such as summing gradient terms in an edge-detection pipeline. The operands are split at a fixed boundary into a lower slice and an upper slice. The lower slice is always added.

A small detector looks only at the two upper slices. When both upper slices are all zeros, or both are all ones (sign extension), the upper result can be worked out without an adder. In that case the upper adder's operands are forced to zero, so its gates do not toggle. The upper result is then rebuilt from the lower slice's carry and the detected pattern. In every other case the upper slices pass unchanged into a real adder.

A flag reports whether the upper adder did work. An output stage, chosen by a parameter, either registers the sum, the carry and the flag with one cycle of latency or passes them straight through.

Top module: `gated_split_adder`

## Requirements
- R1: The operands are `WIDTH` bits wide (default 16). They split into a lower slice of `LO_W` bits (default 8) and an upper slice of `WIDTH-LO_W` bits. The lower slice is always added with `cin` as its carry-in.
- R2: The upper adder is treated as not needed exactly when both upper slices are all zeros or both are all ones. `hi_active` is 1 when the upper adder is used and 0 when it is bypassed.
- R3: When the upper adder is bypassed, both of its operand inputs are all zeros.
- R4: When the upper adder is used, its operand inputs equal the two upper operand slices, unchanged.
- R5: `sum` equals `(opa + opb + cin) mod 2^WIDTH` for every input combination.
- R6: `cout` equals bit `WIDTH` of the plain sum `opa + opb + cin`.
- R7: Both upper slices zero: the upper result holds the lower-slice carry in its bit 0 and zeros above it, and `cout` is 0.
- R8: Both upper slices all ones: the upper result is all ones except bit 0, which holds the lower-slice carry, and `cout` is 1.
- R9: With `REGISTERED=1` (default), `sum`, `cout` and `hi_active` appear one clock after the operands are applied. A synchronous active-low reset clears all three to 0.
- R10: A carry produced by the lower slice reaches the upper result correctly in all three upper modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the lowest bit |
| sum | output | WIDTH | Sum, truncated to WIDTH bits |
| cout | output | 1 | Carry out of the top bit |
| hi_active | output | 1 | 1 when the upper adder was used for this result |

## Verification
The assertions assume that `opa`, `opb` and `cin` are known (no X or Z) at every clock edge outside reset. They also assume that, in registered mode, each result is checked against the operands present one edge earlier. The bench changes the operands only on falling edges and holds them for a whole cycle, so every rising edge sees one stable, fully defined operand set. Random operands are biased so that both bypass patterns occur often. Directed cases force lower-slice carries into each upper mode.

// File: rtl/gsa_pkg.sv
// Shared types for the operand-gated split adder.
// Assumes: imported by every module of the block.
package gsa_pkg;
    // Upper-slice handling chosen by the detector
    typedef enum logic [1:0] {
        HI_ADD  = 2'b00,  // real addition required
        HI_ZERO = 2'b01,  // both upper slices all zeros
        HI_ONES = 2'b10   // both upper slices all ones
    } hi_mode_e;
endpackage

// File: rtl/gsa_lo_adder.sv
// Lower-slice adder: always active, produces the boundary carry.
// Assumes: LO_W >= 1.
module gsa_lo_adder #(
    parameter int LO_W = 8
) (
    input  logic [LO_W-1:0] a,
    input  logic [LO_W-1:0] b,
    input  logic            cin,
    output logic [LO_W-1:0] sum,
    output logic            cout
);
    logic [LO_W:0] full;

    // Plain ripple-free behavioural add with carry
    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{LO_W{1'b0}}, cin};
        sum  = full[LO_W-1:0];
        cout = full[LO_W];
    end
endmodule

// File: rtl/gsa_hi_detect.sv
// Detection unit: examines only the upper operand slices and decides
// whether the upper adder is needed.
// Assumes: HI_W >= 1; inputs are the raw upper slices.
module gsa_hi_detect
    import gsa_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic [HI_W-1:0] a_hi,
    input  logic [HI_W-1:0] b_hi,
    output hi_mode_e        mode,
    output logic            need
);
    logic a_zero, b_zero, a_ones, b_ones;

    // Reduce each slice to its zero / all-ones pattern
    always_comb begin
        a_zero = ~|a_hi;
        b_zero = ~|b_hi;
        a_ones = &a_hi;
        b_ones = &b_hi;
    end

    // Classify the pair into a handling mode
    always_comb begin
        if (a_zero && b_zero) begin
            mode = HI_ZERO;
        end else if (a_ones && b_ones) begin
            mode = HI_ONES;
        end else begin
            mode = HI_ADD;
        end
        need = (mode == HI_ADD);
    end
endmodule

// File: rtl/gsa_hi_path.sv
// Upper-slice path: input gating, the gated adder and the bypass
// reconstruction from the boundary carry and detected pattern.
// Assumes: mode comes from gsa_hi_detect on the same slices.
module gsa_hi_path
    import gsa_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  hi_mode_e        mode,
    input  logic            need,
    input  logic [HI_W-1:0] a_hi,
    input  logic [HI_W-1:0] b_hi,
    input  logic            c_lo,
    output logic [HI_W-1:0] gated_a,
    output logic [HI_W-1:0] gated_b,
    output logic [HI_W-1:0] sum_hi,
    output logic            cout
);
    logic [HI_W:0]   add_full;
    logic            gated_c;
    logic [HI_W-1:0] ones_rebuild;
    logic [HI_W-1:0] zero_rebuild;

    // Force the adder operands to zero when bypassed so it holds still
    always_comb begin
        gated_a = need ? a_hi : '0;
        gated_b = need ? b_hi : '0;
        gated_c = need & c_lo;
    end

    // Upper adder, fed only through the gates
    always_comb begin
        add_full = {1'b0, gated_a} + {1'b0, gated_b} + {{HI_W{1'b0}}, gated_c};
    end

    // Bypass results built from the boundary carry alone
    always_comb begin
        zero_rebuild    = '0;
        zero_rebuild[0] = c_lo;
        ones_rebuild    = '1;
        ones_rebuild[0] = c_lo;
    end

    // Select the upper result by mode
    always_comb begin
        unique case (mode)
            HI_ZERO: begin
                sum_hi = zero_rebuild;
                cout   = 1'b0;
            end
            HI_ONES: begin
                sum_hi = ones_rebuild;
                cout   = 1'b1;
            end
            default: begin
                sum_hi = add_full[HI_W-1:0];
                cout   = add_full[HI_W];
            end
        endcase
    end
endmodule

// File: rtl/gsa_out_stage.sv
// Optional output stage: a register with synchronous active-low reset,
// or a straight pass-through, chosen by REGISTERED.
// Assumes: W >= 1.
module gsa_out_stage #(
    parameter int W          = 16,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_sum,
    input  logic         d_cout,
    input  logic         d_flag,
    output logic [W-1:0] q_sum,
    output logic         q_cout,
    output logic         q_flag
);
    generate
        if (REGISTERED) begin : g_reg
            // Capture the result once per clock, clearing on reset
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    q_sum  <= '0;
                    q_cout <= 1'b0;
                    q_flag <= 1'b0;
                end else begin
                    q_sum  <= d_sum;
                    q_cout <= d_cout;
                    q_flag <= d_flag;
                end
            end
        end else begin : g_comb
            // Pass the result straight through
            always_comb begin
                q_sum  = d_sum;
                q_cout = d_cout;
                q_flag = d_flag;
            end
        end
    endgenerate
endmodule

// File: rtl/gated_split_adder.sv
// Top: split adder whose upper half is input-gated when the detector
// finds its sum derivable from the lower carry.
// Assumes: 1 <= LO_W < WIDTH; clk/rst_n used only when REGISTERED=1.
module gated_split_adder
    import gsa_pkg::*;
#(
    parameter int WIDTH      = 16,
    parameter int LO_W       = 8,
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             hi_active
);
    localparam int HI_W = WIDTH - LO_W;

    logic [LO_W-1:0] lo_sum;
    logic            lo_cout;
    hi_mode_e        hi_mode;
    logic            hi_need;
    logic [HI_W-1:0] hi_ga;
    logic [HI_W-1:0] hi_gb;
    logic [HI_W-1:0] hi_sum;
    logic            hi_cout;
    logic [WIDTH-1:0] comb_sum;

    gsa_lo_adder #(.LO_W(LO_W)) u_lo (
        .a    (opa[LO_W-1:0]),
        .b    (opb[LO_W-1:0]),
        .cin  (cin),
        .sum  (lo_sum),
        .cout (lo_cout)
    );

    gsa_hi_detect #(.HI_W(HI_W)) u_det (
        .a_hi (opa[WIDTH-1:LO_W]),
        .b_hi (opb[WIDTH-1:LO_W]),
        .mode (hi_mode),
        .need (hi_need)
    );

    gsa_hi_path #(.HI_W(HI_W)) u_hi (
        .mode    (hi_mode),
        .need    (hi_need),
        .a_hi    (opa[WIDTH-1:LO_W]),
        .b_hi    (opb[WIDTH-1:LO_W]),
        .c_lo    (lo_cout),
        .gated_a (hi_ga),
        .gated_b (hi_gb),
        .sum_hi  (hi_sum),
        .cout    (hi_cout)
    );

    // Join the two slices into the full-width result
    always_comb begin
        comb_sum = {hi_sum, lo_sum};
    end

    gsa_out_stage #(.W(WIDTH), .REGISTERED(REGISTERED)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_sum  (comb_sum),
        .d_cout (hi_cout),
        .d_flag (hi_need),
        .q_sum  (sum),
        .q_cout (cout),
        .q_flag (hi_active)
    );
endmodule

// File: rtl/gsa_checker.sv
// Checker for gated_split_adder, bound to every instance of it.
// Assumes: inputs are known at each clock edge outside reset.
module gsa_checker #(
    parameter int WIDTH      = 16,
    parameter int LO_W       = 8,
    parameter bit REGISTERED = 1'b1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [WIDTH-1:0]   opa,
    input logic [WIDTH-1:0]   opb,
    input logic               cin,
    input logic [WIDTH-1:0]   sum,
    input logic               cout,
    input logic               hi_active,
    input logic               hi_need,
    input logic [WIDTH-LO_W-1:0] hi_ga,
    input logic [WIDTH-LO_W-1:0] hi_gb
);
    localparam int HI_W = WIDTH - LO_W;

    logic [WIDTH:0] plain;
    logic           both_zero;
    logic           both_ones;

    // Independent reference values taken from the ports
    always_comb begin
        plain     = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
        both_zero = (opa[WIDTH-1:LO_W] == '0) && (opb[WIDTH-1:LO_W] == '0);
        both_ones = (opa[WIDTH-1:LO_W] == '1) && (opb[WIDTH-1:LO_W] == '1);
    end

    // R3
    gate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (both_zero || both_ones) |-> (hi_ga == '0 && hi_gb == '0));

    // R4
    pass_thru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(both_zero || both_ones) |->
            (hi_ga == opa[WIDTH-1:LO_W] && hi_gb == opb[WIDTH-1:LO_W]));

    generate
        if (REGISTERED) begin : g_seq
            // R5
            sum_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> sum == $past(plain[WIDTH-1:0]));
            // R6
            carry_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> cout == $past(plain[WIDTH]));
            // R2
            flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> hi_active == !$past(both_zero || both_ones));
            // R8
            ones_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
                both_ones |=> cout);
        end else begin : g_comb
            // R5
            sum_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
                sum == plain[WIDTH-1:0]);
            // R6
            carry_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cout == plain[WIDTH]);
            // R2
            flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
                hi_active == !(both_zero || both_ones));
            // R8
            ones_cout_chk: assert property (@(posedge clk) disable iff (!rst_n)
                both_ones |-> cout);
        end
    endgenerate
endmodule

bind gated_split_adder gsa_checker #(
    .WIDTH      (WIDTH),
    .LO_W       (LO_W),
    .REGISTERED (REGISTERED)
) u_gsa_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .opa       (opa),
    .opb       (opb),
    .cin       (cin),
    .sum       (sum),
    .cout      (cout),
    .hi_active (hi_active),
    .hi_need   (hi_need),
    .hi_ga     (hi_ga),
    .hi_gb     (hi_gb)
);

// File: tb/tb_gated_split_adder.sv
// Self-checking bench: fixed-seed random operands biased toward the
// bypass patterns, plus directed boundary-carry cases.
module tb_gated_split_adder;
    localparam int W  = 16;
    localparam int LW = 8;
    localparam int HW = W - LW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    logic         hi_active;

    int  checks = 0;
    int  fails  = 0;
    int  cycles = 0;
    bit  done   = 1'b0;

    gated_split_adder #(.WIDTH(W), .LO_W(LW), .REGISTERED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .opa(opa), .opb(opb), .cin(cin),
        .sum(sum), .cout(cout), .hi_active(hi_active)
    );

    always #4 clk = ~clk;  // 125 MHz

    // Expected {cout, sum} from a plain addition
    function automatic logic [W:0] ref_add(logic [W-1:0] a, logic [W-1:0] b, logic c);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endfunction

    // Expected flag: upper adder used unless both slices are 0s or 1s
    function automatic logic ref_flag(logic [W-1:0] a, logic [W-1:0] b);
        logic z, o;
        z = (a[W-1:LW] == '0) && (b[W-1:LW] == '0);
        o = (a[W-1:LW] == '1) && (b[W-1:LW] == '1);
        return !(z || o);
    endfunction

    task automatic check(string req, logic [W:0] act, logic [W:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one operand set, then check the registered result
    task automatic apply(logic [W-1:0] a, logic [W-1:0] b, logic c, string req);
        logic [W:0] prev;
        @(negedge clk);
        prev = {cout, sum};
        opa = a; opb = b; cin = c;
        #1;
        // R9: output must not move before the next rising edge
        check("R9 latency hold", {cout, sum}, prev);
        @(negedge clk);
        check({req, " R5 R6 sum"}, {cout, sum}, ref_add(a, b, c));
        // R2 R3 R4: flag tells which of gated/ungated paths was taken
        check({req, " R2 R3 R4 flag"}, {{W{1'b0}}, hi_active}, {{W{1'b0}}, ref_flag(a, b)});
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 reset", {cout, sum}, '0);
        check("R9 reset flag", {{W{1'b0}}, hi_active}, '0);
        rst_n = 1'b1;

        // R7 R10: both upper zero, lower carry set and clear
        apply(16'h00FF, 16'h0001, 1'b0, "R7 R10 zero carry");
        check("R7 upper", {1'b0, sum[W-1:LW]}, {1'b0, 8'h01});
        apply(16'h0012, 16'h0034, 1'b1, "R7 zero nocarry");
        apply(16'h00FF, 16'h00FF, 1'b1, "R7 R10 zero maxlow");
        // R8 R10: both upper ones
        apply(16'hFF80, 16'hFF80, 1'b0, "R8 R10 ones carry");
        check("R8 upper", {1'b0, sum[W-1:LW]}, {1'b0, 8'hFF});
        apply(16'hFF01, 16'hFF02, 1'b0, "R8 ones nocarry");
        check("R8 upper nc", {1'b0, sum[W-1:LW]}, {1'b0, 8'hFE});
        check("R8 cout", {{W{1'b0}}, cout}, {{W{1'b0}}, 1'b1});
        // R1 R10: upper adder used, carry crosses the split
        apply(16'h01FF, 16'h0001, 1'b0, "R1 R10 add carry");
        apply(16'h7FFF, 16'h0000, 1'b1, "R10 ripple full");
        apply(16'hFFFF, 16'h0001, 1'b0, "R6 wrap");
        apply(16'h00FF, 16'hFF00, 1'b1, "R2 mixed zero/ones");
        apply(16'hFFFF, 16'hFFFF, 1'b1, "R8 all ones");

        // Random, biased toward the two bypass patterns
        for (int i = 0; i < 400; i++) begin
            logic [W-1:0] a, b;
            int sel;
            a = W'($urandom);
            b = W'($urandom);
            sel = int'($urandom_range(3, 0));
            if (sel == 0) begin a[W-1:LW] = '0; b[W-1:LW] = '0; end
            else if (sel == 1) begin a[W-1:LW] = '1; b[W-1:LW] = '1; end
            apply(a, b, 1'($urandom), "R5 random");
        end

        // R9: reset after activity clears outputs
        apply(16'h1234, 16'h4321, 1'b1, "R5 pre-reset");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clear", {cout, sum}, '0);
        check("R9 reset clear flag", {{W{1'b0}}, hi_active}, '0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule